// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a synchronous burst SRAM with a pipelined read path and a small internal array. Every synchronous input is captured on the rising clock edge. Either of two active-low address strobes can open an access: a processor-side strobe that always starts a read, and a controller-side strobe that starts a read or a write depending on the write controls. After the opening cycle, a 2-bit burst counter supplies the next three addresses of the aligned four-word block. It steps in linear or interleaved order, and the order is chosen per burst.

The control path is a three-state machine whose register holds the operation of the first pipeline stage. In `ST_DESEL` the part is deselected. In `ST_READ` the captured address is read into the output register on the next edge. In `ST_WRITE` the selected byte lanes are written on the next edge. The transitions are named as follows. *proc-start* enters `ST_READ`. *ctrl-start* enters `ST_READ` or `ST_WRITE`. *ctrl-deselect* enters `ST_DESEL`. *continue* moves between `ST_READ` and `ST_WRITE`, optionally advancing the counter. *hold* keeps `ST_DESEL`. The output enable gates the data outputs combinationally, outside the pipeline.

Top module: `sburst_sram`

## Requirements
- R1: A read opened by a valid strobe at edge k drives the word at the captured address on `rd_data`, with `rd_oe` high, from edge k+1 onward, provided `oe_n` is low.
- R2: `burst_linear` is sampled at the opening strobe. A value of 1 gives word offset (start + n) mod 4 and a value of 0 gives start XOR n, where start is address bits [1:0] and n is the count. The upper address bits stay fixed for the burst.
- R3: In a cycle with no valid strobe, the count steps by one only when `adv_n` is low. When `adv_n` is high, the same address is accessed again. The count wraps from 3 to 0.
- R4: A valid strobe takes precedence over `adv_n`. It reloads the start offset from the new address bits [1:0] and clears the count.
- R5: A processor strobe with `chip_en_n` low always opens a read, whatever the write controls say. A controller strobe with `chip_en_n` low opens a write if any lane is selected, and a read otherwise.
- R6: With `bwe_n` low and `gwrite_n` high, lane i (bits 8i+7:8i) is written exactly when `byte_we_n[i]` is low, and all other lanes keep their contents. With `bwe_n` high and `gwrite_n` high, no lane is selected.
- R7: With `gwrite_n` low, all four lanes are written, whatever `bwe_n` and `byte_we_n` say.
- R8: A write cycle turns the data outputs off one edge later (`rd_oe` low).
- R9: A controller strobe with `chip_en_n` high deselects the part. The outputs turn off after the next edge and stay off, whatever `adv_n` does, until a valid strobe arrives.
- R10: A processor strobe with `chip_en_n` high is ignored. The cycle behaves as if no strobe were present: an active burst continues, and a deselected part stays deselected.
- R11: `rd_oe` equals (output register valid AND NOT `oe_n`) combinationally, with no clock edge involved. `rd_data` reads zero whenever `rd_oe` is low.
- R12: After reset the part is deselected, with `rd_oe` low and `rd_data` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (6) | Word address, captured on a valid strobe |
| chip_en_n | input | 1 | Active-low chip enable |
| strobe_proc_n | input | 1 | Active-low processor address strobe |
| strobe_ctrl_n | input | 1 | Active-low controller address strobe |
| adv_n | input | 1 | Active-low burst advance |
| burst_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| gwrite_n | input | 1 | Active-low global write (all lanes) |
| bwe_n | input | 1 | Active-low qualifier for the per-lane enables |
| byte_we_n | input | NB (4) | Active-low per-lane write enables |
| wdata | input | 8*NB (32) | Write data |
| oe_n | input | 1 | Active-low asynchronous output enable |
| rd_data | output | 8*NB (32) | Read data, zero when not driven |
| rd_oe | output | 1 | High while read data is driven |

## Verification
Two functions can meet in one cycle: a new strobe and an advance request, and a processor strobe and a deselected chip enable. The bench provokes the first by asserting a strobe with `adv_n` low in the middle of a burst, and judges it by the read-data sequence that follows. That sequence must restart at the new offset. It provokes the second by asserting the processor strobe with `chip_en_n` high, both during an active burst and while deselected. The outputs must show the burst continuing in the first case and staying off in the second. All expected words come from a bench-side array model with addresses computed arithmetically.

// File: rtl/sburst_pkg.sv
package sburst_pkg;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } op_e;

    // Word offset inside the aligned four-word block for count n.
    function automatic logic [1:0] burst_offset(
        input logic [1:0] start,
        input logic [1:0] n,
        input logic       linear
    );
        logic [1:0] sum;
        sum = start + n;
        return linear ? sum : (start ^ n);
    endfunction

endpackage

// File: rtl/sburst_ctrl.sv
module sburst_ctrl
    import sburst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_proc_n,
    input  logic strobe_ctrl_n,
    input  logic chip_en_n,
    input  logic adv_n,
    input  logic wr_req,
    output op_e  op_q,
    output logic load,
    output logic step
);

    op_e  op_d;
    logic proc_go;
    logic ctrl_go;
    logic ctrl_desel;

    always_comb begin
        proc_go    = !strobe_proc_n && !chip_en_n;
        ctrl_go    = !strobe_ctrl_n && !chip_en_n;
        ctrl_desel = !strobe_ctrl_n &&  chip_en_n;
    end

    // Next-state process.
    always_comb begin
        op_d = op_q;
        if (proc_go) begin
            op_d = ST_READ;                           // proc-start
        end else if (ctrl_go) begin
            op_d = wr_req ? ST_WRITE : ST_READ;       // ctrl-start
        end else if (ctrl_desel) begin
            op_d = ST_DESEL;                          // ctrl-deselect
        end else begin
            unique case (op_q)
                ST_DESEL:          op_d = ST_DESEL;   // hold
                ST_READ, ST_WRITE: op_d = wr_req ? ST_WRITE : ST_READ; // continue
                default:           op_d = ST_DESEL;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) op_q <= ST_DESEL;
        else        op_q <= op_d;
    end

    // Output process: counter controls.
    always_comb begin
        load = proc_go || ctrl_go;
        step = 1'b0;
        if (!load && !ctrl_desel) begin
            unique case (op_q)
                ST_READ, ST_WRITE: step = !adv_n;
                default:           step = 1'b0;
            endcase
        end
    end

    p_desel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_ctrl_n && chip_en_n) |=> (op_q == ST_DESEL));

    p_proc_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_proc_n && !chip_en_n) |=> (op_q == ST_READ));

    p_ignored_proc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == ST_DESEL && strobe_ctrl_n && chip_en_n) |=> (op_q == ST_DESEL));

endmodule

// File: rtl/sburst_addr.sv
module sburst_addr
    import sburst_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              mode_linear,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam int BASE_W = ADDR_W - 2;

    logic [BASE_W-1:0] base_q;
    logic [1:0]        start_q;
    logic [1:0]        cnt_q;
    logic              lin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            start_q <= '0;
            cnt_q   <= '0;
            lin_q   <= 1'b0;
        end else if (load) begin
            base_q  <= addr_in[ADDR_W-1:2];
            start_q <= addr_in[1:0];
            cnt_q   <= '0;
            lin_q   <= mode_linear;
        end else if (step) begin
            cnt_q   <= cnt_q + 2'd1;
        end
    end

    always_comb begin
        cur_addr = {base_q, burst_offset(start_q, cnt_q, lin_q)};
    end

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == 2'd0 && cur_addr[1:0] == $past(addr_in[1:0])));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> ($stable(cnt_q) && $stable(cur_addr)));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step) |=> (cnt_q == $past(cnt_q) + 2'd1));

endmodule

// File: rtl/sburst_array.sv
module sburst_array
    import sburst_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NB     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [8*NB-1:0]   wdata,
    input  logic [NB-1:0]     lane_mask,
    output logic [8*NB-1:0]   out_data,
    output logic              out_valid
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [8*NB-1:0] lane_rd;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [7:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (op == ST_WRITE && lane_mask[g]) begin
                mem[addr] <= wdata[g*8 +: 8];
            end
        end

        assign lane_rd[g*8 +: 8] = mem[addr];
    end

    // Output register: second pipeline stage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= (op == ST_READ);
            if (op == ST_READ) out_data <= lane_rd;
        end
    end

    p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ST_WRITE) |=> !out_valid);

    p_read_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ST_READ) |=> out_valid);

    p_desel_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ST_DESEL) |=> !out_valid);

endmodule

// File: rtl/sburst_sram.sv
module sburst_sram
    import sburst_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NB     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              chip_en_n,
    input  logic              strobe_proc_n,
    input  logic              strobe_ctrl_n,
    input  logic              adv_n,
    input  logic              burst_linear,
    input  logic              gwrite_n,
    input  logic              bwe_n,
    input  logic [NB-1:0]     byte_we_n,
    input  logic [8*NB-1:0]   wdata,
    input  logic              oe_n,
    output logic [8*NB-1:0]   rd_data,
    output logic              rd_oe
);

    localparam int DW = 8 * NB;

    op_e               op_q;
    logic              load;
    logic              step;
    logic [NB-1:0]     lane_sel;
    logic [NB-1:0]     mask_q;
    logic [DW-1:0]     wdata_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [DW-1:0]     out_data;
    logic              out_valid;

    // Lane selection: global write overrides the qualified per-lane enables.
    always_comb begin
        if (!gwrite_n)  lane_sel = '1;
        else if (!bwe_n) lane_sel = ~byte_we_n;
        else            lane_sel = '0;
    end

    // First-stage data and mask registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            wdata_q <= '0;
        end else begin
            mask_q  <= lane_sel;
            wdata_q <= wdata;
        end
    end

    sburst_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .strobe_proc_n (strobe_proc_n),
        .strobe_ctrl_n (strobe_ctrl_n),
        .chip_en_n     (chip_en_n),
        .adv_n         (adv_n),
        .wr_req        (|lane_sel),
        .op_q          (op_q),
        .load          (load),
        .step          (step)
    );

    sburst_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .step        (step),
        .addr_in     (addr),
        .mode_linear (burst_linear),
        .cur_addr    (cur_addr)
    );

    sburst_array #(.ADDR_W(ADDR_W), .NB(NB)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op_q),
        .addr      (cur_addr),
        .wdata     (wdata_q),
        .lane_mask (mask_q),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    // Asynchronous output gate.
    always_comb begin
        rd_oe   = out_valid && !oe_n;
        rd_data = rd_oe ? out_data : '0;
    end

    p_write_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !gwrite_n |=> (mask_q == '1));

endmodule

// File: tb/test_sburst_sram.sv
module test_sburst_sram;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        chip_en_n = 1'b0;
    logic        strobe_proc_n = 1'b1;
    logic        strobe_ctrl_n = 1'b1;
    logic        adv_n = 1'b1;
    logic        burst_linear = 1'b0;
    logic        gwrite_n = 1'b1;
    logic        bwe_n = 1'b1;
    logic [3:0]  byte_we_n = 4'hF;
    logic [31:0] wdata = '0;
    logic        oe_n = 1'b0;
    logic [31:0] rd_data;
    logic        rd_oe;

    int n_run = 0;
    int n_fail = 0;

    logic [31:0] model [64];
    int m_st = 0;
    int m_base = 0, m_start = 0, m_cnt = 0;
    logic m_lin = 1'b0;
    logic        prev_v = 1'b0;
    logic [31:0] prev_d = '0;
    string       prev_tag = "R12";

    always #10 clk = ~clk;

    sburst_sram i_sburst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .chip_en_n(chip_en_n),
        .strobe_proc_n(strobe_proc_n), .strobe_ctrl_n(strobe_ctrl_n),
        .adv_n(adv_n), .burst_linear(burst_linear), .gwrite_n(gwrite_n),
        .bwe_n(bwe_n), .byte_we_n(byte_we_n), .wdata(wdata), .oe_n(oe_n),
        .rd_data(rd_data), .rd_oe(rd_oe)
    );

    function automatic logic [31:0] pat(input int a);
        logic [31:0] v;
        v = 32'(a + 1) * 32'h9E37_79B9;
        return v ^ 32'h1234_5678;
    endfunction

    task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual oe=%0b data=%08h expected oe=%0b data=%08h",
                     tag, act[32], act[31:0], exp[32], exp[31:0]);
        end
    endtask

    // One clock cycle: drive, update the model, step, check the previous cycle's result.
    task automatic cyc(input logic pn, input logic cn, input logic cen, input logic advn,
                       input logic lin, input logic gwn, input logic bwen,
                       input logic [3:0] bwn, input int a, input logic [31:0] wd,
                       input string tag);
        logic [3:0]  mask;
        logic        cur_v;
        logic [31:0] cur_d;
        int off, ma;
        strobe_proc_n = pn; strobe_ctrl_n = cn; chip_en_n = cen; adv_n = advn;
        burst_linear = lin; gwrite_n = gwn; bwe_n = bwen; byte_we_n = bwn;
        addr = 6'(a); wdata = wd;
        mask = !gwn ? 4'hF : (!bwen ? ~bwn : 4'h0);
        if (!pn && !cen) begin
            m_st = 1; m_base = a / 4; m_start = a % 4; m_cnt = 0; m_lin = lin;
        end else if (!cn && !cen) begin
            m_st = (mask != 0) ? 2 : 1; m_base = a / 4; m_start = a % 4; m_cnt = 0; m_lin = lin;
        end else if (!cn && cen) begin
            m_st = 0;
        end else if (m_st != 0) begin
            m_st = (mask != 0) ? 2 : 1;
            if (!advn) m_cnt = (m_cnt + 1) % 4;
        end
        off = m_lin ? (m_start + m_cnt) % 4 : (m_start ^ m_cnt);
        ma = m_base * 4 + off;
        if (m_st == 2) begin
            for (int i = 0; i < 4; i++)
                if (mask[i]) model[ma][i*8 +: 8] = wd[i*8 +: 8];
        end
        cur_v = (m_st == 1);
        cur_d = model[ma];
        @(posedge clk);
        @(negedge clk);
        check(prev_tag, {rd_oe, rd_data}, prev_v ? {1'b1, prev_d} : 33'h0);
        prev_v = cur_v; prev_d = cur_d; prev_tag = tag;
    endtask

    task automatic rd_burst(input int a, input logic lin, input string tag);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, lin, 1'b1, 1'b1, 4'hF, a, 32'h0, tag);
        for (int k = 0; k < 3; k++)
            cyc(1'b1, 1'b1, 1'b0, 1'b0, lin, 1'b1, 1'b1, 4'hF, 0, 32'h0, tag);
    endtask

    task automatic idle(input string tag);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 0, 32'h0, tag);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL R1: watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        check("R12", {rd_oe, rd_data}, 33'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", {rd_oe, rd_data}, 33'h0);

        // R7 and R5: fill the array with controller-strobe bursts using the global write.
        for (int b = 0; b < 16; b++) begin
            cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, b * 4, pat(b * 4), "R7");
            for (int k = 1; k < 4; k++)
                cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 0, pat(b * 4 + k), "R7");
        end

        // R2 and R1: every base, start offset and order; processor strobe ignores the write
        // controls on odd bases (R5).
        for (int lin = 0; lin < 2; lin++)
            for (int b = 0; b < 16; b++)
                for (int s = 0; s < 4; s++) begin
                    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'(lin), (b % 2 == 0), 1'b1, 4'hF,
                        b * 4 + s, 32'hDEAD_BEEF, (b % 2 == 0) ? "R2" : "R5");
                    for (int k = 0; k < 3; k++)
                        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'(lin), 1'b1, 1'b1, 4'hF, 0, 32'h0, "R2");
                end

        // R6: every lane subset through the qualified per-lane enables.
        for (int m = 0; m < 16; m++)
            cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, ~4'(m), 32 + m, ~pat(32 + m), "R6");
        // R6: enables without the qualifier select nothing, so this cycle is a read.
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'h0, 51, 32'h0BAD_0BAD, "R6");
        // R7: global write overrides a partial lane pattern.
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'hE, 50, 32'hA5A5_5A5A, "R7");
        for (int b = 8; b < 13; b++) rd_burst(b * 4, 1'b1, "R6");

        // R3: suspend and wrap.
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 7, 32'h0, "R3");
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 0, 32'h0, "R3");
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 0, 32'h0, "R3");
        for (int k = 0; k < 6; k++)
            cyc(1'b1, 1'b1, 1'b0, (k == 2), 1'b0, 1'b1, 1'b1, 4'hF, 0, 32'h0, "R3");

        // R4: strobe with advance low in mid-burst reloads the counter.
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 17, 32'h0, "R4");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 0, 32'h0, "R4");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 42, 32'h0, "R4");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 0, 32'h0, "R4");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 61, 32'h0, "R4");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 0, 32'h0, "R4");

        // R8: write inside a burst turns the outputs off, then is read back.
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 12, 32'h0, "R8");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 0, 32'h0, "R8");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 0, 32'hC0FF_EE00, "R8");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 0, 32'h0, "R8");
        rd_burst(14, 1'b1, "R8");

        // R10 and R9: ignored processor strobe, deselect, and ignored strobe while deselected.
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 20, 32'h0, "R10");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 40, 32'h0, "R10");
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 8, 32'h0, "R9");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 8, 32'h0, "R10");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 0, 32'h0, "R9");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 0, 32'h0, "R9");
        idle("R9");

        // R11: output enable acts without a clock edge.
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 9, 32'h0, "R11");
        idle("R11");
        #2 oe_n = 1'b1;
        #1 check("R11", {rd_oe, rd_data}, 33'h0);
        oe_n = 1'b0;
        #1 check("R11", {rd_oe, rd_data}, {1'b1, model[9]});
        idle("R11");
        idle("R11");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule